// File: doc/BRIEF.md
# Serial ADC Output Emulator

This block stands in for a 16-bit sampling converter on a three-wire serial link. It lets a host controller be tested without real silicon. The host drives an active-low select and a data clock. A pattern source beside the block drives the parallel word that stands for the conversion result. The emulator replays the frame a real converter would produce: a quiet start, leading zeros up to the close of the sampling window, the word most significant bit first, then a least-significant-first echo, then zeros.

Both host inputs are asynchronous to the system clock. They are brought in through synchronizers, and all frame events are counted on their edges. Each data-clock phase is also timed in system clocks. A phase shorter than the configured minimum (200 ns at the chosen clock) raises a timing-error flag. A frame counter counts frames that ran to the end of the echo, so a bench can tell complete frames from aborted ones.

Top module: `adc_emu_serial`

## Requirements
- R1: After reset, and at all times while `cs_n` is high, `sdo_oe` and `sdo` are 0. After reset, `frame_count` and `timing_err` are also 0.
- R2: `dclk` rising edges are counted from the fall of `cs_n`. After the second rising edge, `sdo_oe` is 1 and `sdo` is 0. `sdo` stays 0 through rising edge 5, so the host reads a zero (the null bit) at falling edge 5.
- R3: After rising edges 6 to 21, `sdo` carries word bits 15 down to 0, one per edge, so each bit is valid at the following `dclk` falling edge. `sdo` changes only after a `dclk` rising edge or a change of `cs_n`.
- R4: The word is taken from `sample_word` at the fifth `dclk` falling edge after `cs_n` falls. Values present before that edge have no effect. Changes after that edge do not alter the frame in progress.
- R5: After rising edges 22 to 36, `sdo` carries word bits 1 up to 15, one per edge. This is a least-significant-first echo that shares bit 0 with the first pass.
- R6: After the 36th rising edge, `sdo` stays 0 with `sdo_oe` high until `cs_n` rises. `frame_count` increments by exactly one at the 36th falling edge and counts modulo 2^CNT_W.
- R7: A rise of `cs_n` at any point ends the frame. `sdo_oe` drops, `frame_count` does not change, and the next fall of `cs_n` starts a fresh frame.
- R8: While `cs_n` is low, `timing_err` sets if a `dclk` high or low phase lasts fewer than MIN_PHASE system clocks. The first partial phase after `cs_n` falls is exempt. Phases of MIN_PHASE clocks or more leave the flag clear. The flag clears at the next fall of `cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Host select, low selects, high is shutdown (asynchronous) |
| dclk | input | 1 | Host data clock (asynchronous) |
| sample_word | input | W | Parallel value standing for the conversion result |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Drive enable for `sdo`; 0 means the pin floats |
| timing_err | output | 1 | Sticky flag for a too-short data-clock phase within a frame |
| frame_count | output | CNT_W | Number of fully completed frames |

## Verification
Several rules are checked by assertions on every cycle. The output is quiet one cycle after deselection. `sdo` moves only after a data-clock rise or a select change. The latched word holds outside its capture edge. The error flag sets only on a data-clock edge and clears when a frame starts. The frame counter never steps by more than one. The bench scenarios are needed for the rest: the exact bit order of both passes for each word, which value of `sample_word` is captured relative to the fifth falling edge, the count after an aborted frame, and the flag's response to a deliberately short phase.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;
  // Synchronized view of one asynchronous host line.
  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/adc_emu_sync.sv
module adc_emu_sync
  import adc_emu_pkg::*;
#(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  async_in,
  output edge_t ev
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
      prev  <= RST_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      prev  <= chain[STAGES-1];
    end
  end

  always_comb begin
    ev.lvl  = chain[STAGES-1];
    ev.rise = chain[STAGES-1] & ~prev;
    ev.fall = ~chain[STAGES-1] & prev;
  end
endmodule

// File: rtl/adc_emu_phase_chk.sv
module adc_emu_phase_chk #(
  parameter int MIN_PHASE = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic start,
  input  logic clk_edge,
  output logic err
);
  localparam int CW = $clog2(MIN_PHASE + 1);

  logic [CW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
      err   <= 1'b0;
    end else if (start) begin
      err   <= 1'b0;
      armed <= 1'b0;
      cnt   <= CW'(1);
    end else if (active && clk_edge) begin
      if (armed && (cnt < CW'(MIN_PHASE))) err <= 1'b1;
      armed <= 1'b1;
      cnt   <= CW'(1);
    end else if (cnt < CW'(MIN_PHASE)) begin
      cnt <= cnt + CW'(1);
    end
  end

  AST_ERR_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(clk_edge && active)); // R8
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !err); // R8
endmodule

// File: rtl/adc_emu_frame.sv
module adc_emu_frame #(
  parameter int W            = 16,
  parameter int OE_RISE      = 2,
  parameter int SAMPLE_FALLS = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         start,
  input  logic         rise,
  input  logic         fall,
  input  logic [W-1:0] sample_word,
  output logic         sdo,
  output logic         sdo_oe,
  output logic         done
);
  localparam int DATA_LAST = SAMPLE_FALLS + W;
  localparam int ECHO_LAST = SAMPLE_FALLS + 2 * W - 1;
  localparam int CW        = $clog2(ECHO_LAST + 2);
  localparam int IW        = $clog2(W);

  logic [CW-1:0] rc, fc, rc_nx, fc_nx;
  logic [W-1:0]  word_q;
  logic [IW-1:0] bidx;
  logic          oe_nx, sdo_nx;

  always_comb begin
    rc_nx  = (rc == CW'(ECHO_LAST + 1)) ? rc : rc + CW'(1);
    fc_nx  = (fc == CW'(ECHO_LAST + 1)) ? fc : fc + CW'(1);
    oe_nx  = 1'b1;
    sdo_nx = 1'b0;
    bidx   = '0;
    if (int'(rc_nx) < OE_RISE) begin
      oe_nx = 1'b0;
    end else if (int'(rc_nx) <= SAMPLE_FALLS) begin
      sdo_nx = 1'b0;
    end else if (int'(rc_nx) <= DATA_LAST) begin
      bidx   = IW'(DATA_LAST - int'(rc_nx));
      sdo_nx = word_q[bidx];
    end else if (int'(rc_nx) <= ECHO_LAST) begin
      bidx   = IW'(int'(rc_nx) - DATA_LAST);
      sdo_nx = word_q[bidx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rc     <= '0;
      fc     <= '0;
      word_q <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rc     <= '0;
        fc     <= '0;
        sdo    <= 1'b0;
        sdo_oe <= 1'b0;
      end else if (!active) begin
        sdo    <= 1'b0;
        sdo_oe <= 1'b0;
      end else begin
        if (rise) begin
          rc     <= rc_nx;
          sdo_oe <= oe_nx;
          sdo    <= sdo_nx;
        end
        if (fall) begin
          fc <= fc_nx;
          if (fc_nx == CW'(SAMPLE_FALLS)) word_q <= sample_word;
          if (fc_nx == CW'(ECHO_LAST) && fc != CW'(ECHO_LAST)) done <= 1'b1;
        end
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !sdo_oe); // R1
  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !rise && !start) |=> $stable(sdo)); // R3
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(active && fall && !start) |=> $stable(word_q)); // R4
  AST_DONE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sdo_oe); // R6
endmodule

// File: rtl/adc_emu_serial.sv
module adc_emu_serial
  import adc_emu_pkg::*;
#(
  parameter int W            = 16,
  parameter int MIN_PHASE    = 20,
  parameter int SYNC_STAGES  = 2,
  parameter int OE_RISE      = 2,
  parameter int SAMPLE_FALLS = 5,
  parameter int CNT_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             dclk,
  input  logic [W-1:0]     sample_word,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             timing_err,
  output logic [CNT_W-1:0] frame_count
);
  edge_t cs_ev, dk_ev;
  logic  active, start, done;

  adc_emu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cs_n), .ev(cs_ev));
  adc_emu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_dk_sync (
    .clk(clk), .rst_n(rst_n), .async_in(dclk), .ev(dk_ev));

  assign active = ~cs_ev.lvl;
  assign start  = cs_ev.fall;

  adc_emu_frame #(.W(W), .OE_RISE(OE_RISE), .SAMPLE_FALLS(SAMPLE_FALLS)) u_frame (
    .clk(clk), .rst_n(rst_n), .active(active), .start(start),
    .rise(dk_ev.rise), .fall(dk_ev.fall), .sample_word(sample_word),
    .sdo(sdo), .sdo_oe(sdo_oe), .done(done));

  adc_emu_phase_chk #(.MIN_PHASE(MIN_PHASE)) u_phase (
    .clk(clk), .rst_n(rst_n), .active(active), .start(start),
    .clk_edge(dk_ev.rise | dk_ev.fall), .err(timing_err));

  always_ff @(posedge clk) begin
    if (!rst_n)    frame_count <= '0;
    else if (done) frame_count <= frame_count + CNT_W'(1);
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_count != $past(frame_count)) |-> (frame_count == $past(frame_count) + CNT_W'(1))); // R6
  AST_NO_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_ev.lvl && $past(cs_ev.lvl)) |=> $stable(frame_count)); // R7
endmodule

// File: tb/adc_emu_serial_bench.sv
module adc_emu_serial_bench;
  localparam int HALF  = 25;
  localparam int SHORT = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        dclk = 1'b0;
  logic [15:0] sample_word = '0;
  logic        sdo, sdo_oe, timing_err;
  logic [7:0]  frame_count;

  int  checks = 0;
  int  errors = 0;
  int  exp_frames = 0;
  bit  finished = 0;

  always #5 clk = ~clk;

  adc_emu_serial u_adc_emu_serial (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dclk(dclk),
    .sample_word(sample_word), .sdo(sdo), .sdo_oe(sdo_oe),
    .timing_err(timing_err), .frame_count(frame_count));

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] expect_out(input int k, input logic [15:0] w);
    if (k < 2)        return 2'b00;
    else if (k <= 5)  return 2'b10;
    else if (k <= 21) return {1'b1, w[21-k]};
    else if (k <= 36) return {1'b1, w[k-21]};
    else              return 2'b10;
  endfunction

  function automatic string tag_of(input int k);
    if (k <= 5)       return "R2";
    else if (k <= 21) return "R3 R4";
    else if (k <= 36) return "R5 R4";
    else              return "R6";
  endfunction

  task automatic run_frame(input logic [15:0] early_w, input logic [15:0] final_w,
                           input int nclk, input int short_k, input bit end_frame);
    logic [1:0] e;
    sample_word = early_w;
    cs_n = 1'b0;
    wait_cyc(30);
    chk(timing_err == 1'b0, "R8 clear at select", timing_err, 0);
    chk(sdo_oe == 1'b0, "R2 quiet before clocks", sdo_oe, 0);
    for (int k = 1; k <= nclk; k++) begin
      dclk = 1'b1;
      wait_cyc(k == short_k ? SHORT : HALF);
      e = expect_out(k, final_w);
      chk({sdo_oe, sdo} == e, tag_of(k), int'({sdo_oe, sdo}), int'(e));
      dclk = 1'b0;
      if (k == 3) sample_word = final_w;
      if (k == 5) begin
        wait_cyc(12);
        sample_word = ~final_w;
        wait_cyc(HALF - 12);
      end else begin
        wait_cyc(HALF);
      end
    end
    if (short_k > 1) chk(timing_err == 1'b1, "R8 short phase flagged", timing_err, 1);
    else             chk(timing_err == 1'b0, "R8 legal phases", timing_err, 0);
    cs_n = 1'b1;
    wait_cyc(10);
    chk(sdo_oe == 1'b0 && sdo == 1'b0, "R1 R7 quiet after deselect", int'({sdo_oe, sdo}), 0);
    if (end_frame) exp_frames++;
    chk(frame_count == 8'(exp_frames), end_frame ? "R6 frame counted" : "R7 abort not counted",
        frame_count, exp_frames);
    wait_cyc(20);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    chk(sdo_oe == 1'b0 && sdo == 1'b0, "R1 reset outputs", int'({sdo_oe, sdo}), 0);
    chk(frame_count == 8'd0, "R1 reset count", frame_count, 0);
    chk(timing_err == 1'b0, "R1 reset flag", timing_err, 0);
    dclk = 1'b1; wait_cyc(HALF);
    chk(sdo_oe == 1'b0, "R1 clocks ignored while deselected", sdo_oe, 0);
    dclk = 1'b0; wait_cyc(HALF);

    for (int i = 0; i < 16; i++) begin
      logic [15:0] w = 16'(1) << i;
      run_frame(~w, w, 40, 0, 1'b1);
    end
    for (int j = 0; j < 8; j++) begin
      logic [15:0] w = 16'(j * 16'h9E37 + 16'h1234);
      run_frame(w ^ 16'h5A5A, w, 38, 0, 1'b1);
    end
    run_frame(16'hFFFF, 16'h0000, 37, 0, 1'b1);
    run_frame(16'h0000, 16'hFFFF, 37, 0, 1'b1);
    // R7: abort in the middle of the word, then a clean frame
    run_frame(16'h1111, 16'hC3A5, 12, 0, 1'b0);
    run_frame(16'h2222, 16'h5AC3, 36, 0, 1'b1);
    // R7: abort during the echo, one clock short of completion
    run_frame(16'h3333, 16'h0F0F, 35, 0, 1'b0);
    // R8: a short high phase inside the frame, then a frame that clears it
    run_frame(16'h4444, 16'hBEEF, 36, 3, 1'b1);
    run_frame(16'h5555, 16'h7E81, 36, 0, 1'b1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule